// File: doc/BRIEF.md
# Double-Buffered Parallel DAC Register Front End

This block is the digital side of a 12-bit voltage-output converter with a parallel write port of the kind a microprocessor drives. Active-low chip-select, write-enable and load strobes come in, along with a register-select line and a 12-bit data bus. Each accepted write goes either to a holding register or to a control word. A separate load strobe moves the holding register into the code register that feeds the converter. A host can stage a new code and update the output later. It can also hold the load strobe low so that every data write reaches the output on its own.

All strobes are asynchronous to the system clock. The block synchronises them, detects the rising write edge in the clock domain, and captures the bus value that was present just before that edge. The control word is decoded into a speed mode, a power-down status, a reference selection and an enable for the internal reference buffer. An ideal output level in millivolts is computed from the loaded code and the selected reference. A timing checker measures pulse widths, setup and hold in clock cycles and raises one sticky flag for each rule that is broken.

Top module: `dac_pif`

## Requirements
- R1: A write is accepted only on a rising edge of `we_n_i` while `cs_n_i` is low. The captured bus value is the one sampled on the clock edge before the rising write edge is sampled. With the load strobe held low, the new code appears on `code_o` at the third rising clock edge after the write-enable rise.
- R2: `sel_ctrl_i` = 0 sends the write to the holding register. `sel_ctrl_i` = 1 sends it to the control word. A write to one target leaves the other unchanged.
- R3: While the synchronised `ld_n_i` is low, `code_o` takes the holding register value. While it is high, `code_o` keeps its value, so holding-register writes stay invisible until a load pulse.
- R4: If a holding-register write and an active load fall in the same cycle, the code register takes the newly written value in the next cycle. With the load held low permanently, every data write therefore reaches `code_o`.
- R5: Reset (synchronous, active high) clears the holding register, the code register, the control word and all violation flags.
- R6: Control bit 0 selects speed (1 = fast, 0 = slow) and drives `fast_o`. Control bit 1 is power-down (1 = down) and drives `pwrdn_o`. Bit 2 and bits 11..5 have no effect on any output.
- R7: Control bits 4:3 form the reference select on `ref_sel_o`: 01 selects internal 2048 mV, 10 selects internal 1024 mV, and 00 and 11 select the external reference. `ref_buf_en_o` is 1 only for the two internal selections.
- R8: Entering or leaving power-down changes no register. `code_o` keeps the loaded code throughout and still shows it after normal operation resumes.
- R9: `vout_mv_o` equals floor(2 * ref_mv * code / 4096), clamped to `VDD_MV`. Here ref_mv is 2048, 1024 or `EXT_REF_MV` according to R7.
- R10: Flag bit 0 sets when write-enable falls while chip-select has been low for fewer than `CS_SU` cycles. Flag bit 4 sets when write-enable falls, with chip-select low, after a high time of fewer than `WE_HI` cycles.
- R11: For an accepted write, flag bit 1 sets if the data bits were stable for fewer than `D_SU` cycles before the rise. Flag bit 2 sets if register-select was stable for fewer than `R_SU` cycles before the rise. Flag bit 3 sets if data or register-select changes within `HOLD` cycles from the rise.
- R12: Flag bit 5 sets when the load strobe rises after a low time of fewer than `LD_LO` cycles. Flag bit 6 sets when the load strobe falls fewer than `WE_LD` cycles after a write-enable rise, including in the same cycle.
- R13: Each flag stays set until reset. Legal write and load sequences set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dat_i | input | 12 | Parallel data bus |
| sel_ctrl_i | input | 1 | Target select: 0 holding register, 1 control word |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| we_n_i | input | 1 | Write enable, active low, data taken on its rising edge |
| ld_n_i | input | 1 | Load strobe, active low, level sensitive, asynchronous |
| code_o | output | 12 | Code register driving the converter |
| fast_o | output | 1 | Fast settling mode selected |
| pwrdn_o | output | 1 | Power-down status |
| ref_sel_o | output | 2 | Reference select field |
| ref_buf_en_o | output | 1 | Internal reference buffer enable |
| vout_mv_o | output | 16 | Ideal output level in millivolts |
| viol_o | output | 7 | Sticky timing violation flags |

## Verification
The two functions that can land in the same cycle are a holding-register write and an active load. The bench provokes this by keeping the load strobe low for a whole sweep of all 4096 codes. Each write then reaches the code register in the cycle where the load is also copying the holding register, and the result must be the new value rather than the stale one. Each code is judged on `code_o` and on the computed output level. A second collision, a load falling in the same cycle as a write-enable rise, is provoked on purpose and must raise only the write-to-load flag.

// File: rtl/dac_pif_pkg.sv
package dac_pif_pkg;

    localparam int INT_HI_MV = 2048;
    localparam int INT_LO_MV = 1024;
    localparam int NUM_RULES = 7;

    typedef enum logic [1:0] {
        REF_EXT_A = 2'b00,
        REF_INT_HI = 2'b01,
        REF_INT_LO = 2'b10,
        REF_EXT_B = 2'b11
    } ref_src_e;

    typedef enum int {
        RULE_CS_SU = 0,
        RULE_D_SU  = 1,
        RULE_R_SU  = 2,
        RULE_HOLD  = 3,
        RULE_WE_HI = 4,
        RULE_LD_LO = 5,
        RULE_WE_LD = 6
    } rule_e;

    typedef struct packed {
        logic     fast;
        logic     pwrdn;
        ref_src_e ref_src;
        logic     buf_en;
    } ctrl_dec_t;

    function automatic ctrl_dec_t decode_ctrl(input logic [4:0] low_bits);
        ctrl_dec_t r;
        r.fast    = low_bits[0];
        r.pwrdn   = low_bits[1];
        r.ref_src = ref_src_e'(low_bits[4:3]);
        r.buf_en  = (r.ref_src == REF_INT_HI) || (r.ref_src == REF_INT_LO);
        return r;
    endfunction

    function automatic int ref_level_mv(input ref_src_e src, input int ext_mv);
        case (src)
            REF_INT_HI: return INT_HI_MV;
            REF_INT_LO: return INT_LO_MV;
            default:    return ext_mv;
        endcase
    endfunction

    function automatic int ideal_mv(input int ref_mv, input int code, input int dw, input int vdd_mv);
        int full;
        full = (2 * ref_mv * code) >>> dw;
        return (full > vdd_mv) ? vdd_mv : full;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dac_pif_sync.sv
module dac_pif_sync #(
    parameter int   W       = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[k] <= {W{RST_VAL}};
            end else if (k == 0) begin
                stage_q[k] <= d_i;
            end else begin
                stage_q[k] <= stage_q[(k == 0) ? 0 : k-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dac_pif_regs.sv
module dac_pif_regs #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_stb,
    input  logic          cs_p,
    input  logic [DW:0]   bus_p,
    input  logic          ld_s,
    output logic [DW-1:0] code_o,
    output logic [DW-1:0] ctrl_o
);
    logic [DW-1:0] hold_q;
    logic [DW-1:0] ctrl_q;
    logic [DW-1:0] code_q;
    logic          wr_ok;
    logic          wr_hold;
    logic          wr_ctrl;

    assign wr_ok   = wr_stb && !cs_p;
    assign wr_hold = wr_ok && !bus_p[DW];
    assign wr_ctrl = wr_ok &&  bus_p[DW];

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            ctrl_q <= '0;
            code_q <= '0;
        end else begin
            if (wr_hold) hold_q <= bus_p[DW-1:0];
            if (wr_ctrl) ctrl_q <= bus_p[DW-1:0];
            if (!ld_s)   code_q <= wr_hold ? bus_p[DW-1:0] : hold_q;
        end
    end

    assign code_o = code_q;
    assign ctrl_o = ctrl_q;

    AST_LD_IDLE_KEEP: assert property (@(posedge clk) disable iff (rst) ld_s |=> $stable(code_o)); // R3
    AST_LD_COPY: assert property (@(posedge clk) disable iff (rst) (!ld_s && !wr_hold) |=> (code_o == $past(hold_q))); // R3
    AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst) (!ld_s && wr_hold) |=> (code_o == $past(bus_p[DW-1:0]))); // R4
    AST_CTRL_UNTOUCHED: assert property (@(posedge clk) disable iff (rst) wr_hold |=> $stable(ctrl_o)); // R2
endmodule

// File: rtl/dac_pif_timing.sv
module dac_pif_timing
    import dac_pif_pkg::*;
#(
    parameter int DW    = 12,
    parameter int CS_SU = 2,
    parameter int D_SU  = 2,
    parameter int R_SU  = 3,
    parameter int HOLD  = 1,
    parameter int WE_HI = 2,
    parameter int LD_LO = 3,
    parameter int WE_LD = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we_s,
    input  logic                 we_p,
    input  logic                 cs_s,
    input  logic                 cs_p,
    input  logic                 ld_s,
    input  logic [DW:0]          bus_s,
    input  logic [DW:0]          bus_p,
    output logic [NUM_RULES-1:0] viol_o
);
    localparam int LIM = max_of(max_of(max_of(CS_SU, D_SU), max_of(R_SU, HOLD)),
                                max_of(max_of(WE_HI, LD_LO), WE_LD));
    localparam int CW = $clog2(LIM + 2) + 1;
    localparam logic [CW-1:0] CMAX = '1;

    logic          ld_p;
    logic [CW-1:0] cs_run, we_hi_run, ld_lo_run, d_age, r_age, since_we, hold_rem;
    logic [DW:0]   hold_ref;
    logic          rise, fall, ld_fall, ld_rise, acc;
    logic [NUM_RULES-1:0] v_now;
    logic [NUM_RULES-1:0] viol_q;

    function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
        return (v == CMAX) ? v : v + 1'b1;
    endfunction

    assign rise    =  we_s && !we_p;
    assign fall    = !we_s &&  we_p;
    assign ld_fall = !ld_s &&  ld_p;
    assign ld_rise =  ld_s && !ld_p;
    assign acc     = rise && !cs_p;

    always_comb begin
        v_now = '0;
        v_now[RULE_CS_SU] = fall && !cs_s && (int'(cs_run) < CS_SU);
        v_now[RULE_D_SU]  = acc && (int'(d_age) < D_SU);
        v_now[RULE_R_SU]  = acc && (int'(r_age) < R_SU);
        v_now[RULE_HOLD]  = (acc && (HOLD > 0) && (bus_s != bus_p)) ||
                            ((hold_rem != '0) && (bus_s != hold_ref));
        v_now[RULE_WE_HI] = fall && !cs_s && (int'(we_hi_run) < WE_HI);
        v_now[RULE_LD_LO] = ld_rise && (int'(ld_lo_run) < LD_LO);
        v_now[RULE_WE_LD] = ld_fall && (rise || (int'(since_we) + 1 < WE_LD));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_p      <= 1'b1;
            cs_run    <= '0;
            we_hi_run <= '0;
            ld_lo_run <= '0;
            d_age     <= '0;
            r_age     <= '0;
            since_we  <= CMAX;
            hold_rem  <= '0;
            hold_ref  <= '0;
            viol_q    <= '0;
        end else begin
            ld_p      <= ld_s;
            cs_run    <= cs_s ? '0 : sat_inc(cs_run);
            we_hi_run <= we_s ? sat_inc(we_hi_run) : '0;
            ld_lo_run <= ld_s ? '0 : sat_inc(ld_lo_run);
            d_age     <= (bus_s[DW-1:0] == bus_p[DW-1:0]) ? sat_inc(d_age) : CW'(1);
            r_age     <= (bus_s[DW] == bus_p[DW]) ? sat_inc(r_age) : CW'(1);
            since_we  <= rise ? '0 : sat_inc(since_we);
            if (acc) begin
                hold_ref <= bus_p;
                hold_rem <= (HOLD > 0) ? CW'(HOLD - 1) : '0;
            end else if (hold_rem != '0) begin
                hold_rem <= hold_rem - 1'b1;
            end
            viol_q <= viol_q | v_now;
        end
    end

    assign viol_o = viol_q;

    for (genvar i = 0; i < NUM_RULES; i++) begin : g_sticky
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst) viol_o[i] |=> viol_o[i]); // R13
    end
    AST_LD_LATE_FLAG: assert property (@(posedge clk) disable iff (rst) (ld_fall && rise) |=> viol_o[RULE_WE_LD]); // R12
endmodule

// File: rtl/dac_pif.sv
module dac_pif
    import dac_pif_pkg::*;
#(
    parameter int DW         = 12,
    parameter int VW         = 16,
    parameter int EXT_REF_MV = 1500,
    parameter int VDD_MV     = 3300,
    parameter int CS_SU      = 2,
    parameter int D_SU       = 2,
    parameter int R_SU       = 3,
    parameter int HOLD       = 1,
    parameter int WE_HI      = 2,
    parameter int LD_LO      = 3,
    parameter int WE_LD      = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DW-1:0]        dat_i,
    input  logic                 sel_ctrl_i,
    input  logic                 cs_n_i,
    input  logic                 we_n_i,
    input  logic                 ld_n_i,
    output logic [DW-1:0]        code_o,
    output logic                 fast_o,
    output logic                 pwrdn_o,
    output logic [1:0]           ref_sel_o,
    output logic                 ref_buf_en_o,
    output logic [VW-1:0]        vout_mv_o,
    output logic [NUM_RULES-1:0] viol_o
);
    logic [2:0]    strb_s;
    logic          we_s, cs_s, ld_s;
    logic          we_p, cs_p;
    logic [DW:0]   bus_s, bus_p;
    logic [DW-1:0] ctrl_w;
    ctrl_dec_t     dec;

    dac_pif_sync #(.W(3), .STAGES(2), .RST_VAL(1'b1)) u_sync_strb (
        .clk (clk),
        .rst (rst),
        .d_i ({we_n_i, cs_n_i, ld_n_i}),
        .q_o (strb_s)
    );
    assign {we_s, cs_s, ld_s} = strb_s;

    dac_pif_sync #(.W(DW + 1), .STAGES(2), .RST_VAL(1'b0)) u_sync_bus (
        .clk (clk),
        .rst (rst),
        .d_i ({sel_ctrl_i, dat_i}),
        .q_o (bus_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            we_p  <= 1'b1;
            cs_p  <= 1'b1;
            bus_p <= '0;
        end else begin
            we_p  <= we_s;
            cs_p  <= cs_s;
            bus_p <= bus_s;
        end
    end

    dac_pif_regs #(.DW(DW)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_stb (we_s && !we_p),
        .cs_p   (cs_p),
        .bus_p  (bus_p),
        .ld_s   (ld_s),
        .code_o (code_o),
        .ctrl_o (ctrl_w)
    );

    dac_pif_timing #(
        .DW(DW), .CS_SU(CS_SU), .D_SU(D_SU), .R_SU(R_SU), .HOLD(HOLD),
        .WE_HI(WE_HI), .LD_LO(LD_LO), .WE_LD(WE_LD)
    ) u_timing (
        .clk    (clk),
        .rst    (rst),
        .we_s   (we_s),
        .we_p   (we_p),
        .cs_s   (cs_s),
        .cs_p   (cs_p),
        .ld_s   (ld_s),
        .bus_s  (bus_s),
        .bus_p  (bus_p),
        .viol_o (viol_o)
    );

    assign dec          = decode_ctrl(ctrl_w[4:0]);
    assign fast_o       = dec.fast;
    assign pwrdn_o      = dec.pwrdn;
    assign ref_sel_o    = dec.ref_src;
    assign ref_buf_en_o = dec.buf_en;
    assign vout_mv_o    = VW'(ideal_mv(ref_level_mv(dec.ref_src, EXT_REF_MV), int'(code_o), DW, VDD_MV));

    AST_PD_CODE_KEEP: assert property (@(posedge clk) disable iff (rst) (ld_s && $changed(pwrdn_o)) |-> $stable(code_o)); // R8
    AST_VOUT_CLAMP: assert property (@(posedge clk) disable iff (rst) int'(vout_mv_o) <= VDD_MV); // R9
endmodule

// File: tb/dac_pif_tb.sv
module dac_pif_tb;
    localparam int CLK_NS = 10;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] dat = '0;
    logic          sel = 1'b0;
    logic          cs_n = 1'b1;
    logic          we_n = 1'b1;
    logic          ld_n = 1'b1;
    logic [DW-1:0] code;
    logic          fast, pwrdn, buf_en;
    logic [1:0]    rsel;
    logic [15:0]   vout;
    logic [6:0]    viol;

    int n_run = 0;
    int n_fail = 0;
    int hold_m = 0, code_m = 0, ctrl_m = 0;
    bit ld_low_m = 0;

    dac_pif u_dut (
        .clk(clk), .rst(rst), .dat_i(dat), .sel_ctrl_i(sel), .cs_n_i(cs_n),
        .we_n_i(we_n), .ld_n_i(ld_n), .code_o(code), .fast_o(fast), .pwrdn_o(pwrdn),
        .ref_sel_o(rsel), .ref_buf_en_o(buf_en), .vout_mv_o(vout), .viol_o(viol)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; tick(3); rst = 1'b0; tick(6);
        hold_m = 0; code_m = 0; ctrl_m = 0;
    endtask

    task automatic wr(input bit s, input int v, input bit en);
        cs_n = !en; sel = s; dat = DW'(v);
        tick(3); we_n = 1'b0; tick(3); we_n = 1'b1; tick(2); cs_n = 1'b1; tick(4);
        if (en) begin
            if (s) ctrl_m = v; else hold_m = v;
            if (ld_low_m) code_m = hold_m;
        end
    endtask

    task automatic ld_pulse();
        ld_n = 1'b0; tick(4); ld_n = 1'b1; tick(4);
        code_m = hold_m;
    endtask

    function automatic int exp_vout(input int c, input int ctl);
        int r;
        r = (((ctl >> 3) & 3) == 1) ? 2048 : (((ctl >> 3) & 3) == 2) ? 1024 : 1500;
        r = (2 * r * c) / 4096;
        return (r > 3300) ? 3300 : r;
    endfunction

    task automatic chk_ctrl(input string tag);
        int rs;
        rs = (ctrl_m >> 3) & 3;
        chk({tag, " R6 fast"}, int'(fast), ctrl_m & 1);
        chk({tag, " R6 pwrdn"}, int'(pwrdn), (ctrl_m >> 1) & 1);
        chk({tag, " R7 refsel"}, int'(rsel), rs);
        chk({tag, " R7 bufen"}, int'(buf_en), (rs == 1 || rs == 2) ? 1 : 0);
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_fail++;
        $display("FAIL watchdog R1 got=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R5: reset state
        chk("R5 code", int'(code), 0);
        chk("R5 viol", int'(viol), 0);
        chk_ctrl("R5");
        chk("R5 vout", int'(vout), 0);

        // R3 / R2: staged write invisible until load pulse
        wr(1'b0, 12'hA5C, 1'b1);
        chk("R3 staged no load", int'(code), 0);
        chk("R2 ctrl untouched", int'({fast, pwrdn, rsel}), 0);
        ld_pulse();
        chk("R3 load copy", int'(code), code_m);
        wr(1'b0, 12'h123, 1'b1);
        chk("R3 idle load keeps", int'(code), code_m);
        ld_pulse();
        chk("R3 second load", int'(code), 12'h123);

        // R5: reset clears loaded state
        do_reset();
        chk("R5 code after data", int'(code), 0);

        // R4 / R1 / R9: load held low, full code sweep with 2048 mV reference
        wr(1'b1, 12'h008, 1'b1);
        ld_n = 1'b0; ld_low_m = 1; tick(4); code_m = hold_m;
        for (int c = 0; c < 4096; c++) begin
            wr(1'b0, c, 1'b1);
            chk("R4 auto update", int'(code), c);
            chk("R9 vout hi", int'(vout), exp_vout(c, ctrl_m));
        end

        // R1: latency, code visible at third rising edge after WE rise
        cs_n = 1'b0; sel = 1'b0; dat = 12'h3C3; tick(3); we_n = 1'b0; tick(3); we_n = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        chk("R1 not yet at 2nd edge", int'(code), 4095);
        @(posedge clk); #1;
        chk("R1 visible at 3rd edge", int'(code), 12'h3C3);
        tick(2); cs_n = 1'b1; tick(4);
        hold_m = 12'h3C3; code_m = hold_m;

        // R1: write with chip select high is ignored
        wr(1'b0, 12'h777, 1'b0);
        chk("R1 cs high ignored", int'(code), 12'h3C3);
        wr(1'b1, 12'h01B, 1'b0);
        chk("R1 cs high ctrl ignored", int'(fast), 0);

        // R9: other references and clamp
        for (int k = 0; k < 3; k++) begin
            int cv = (k == 0) ? 12'h010 : (k == 1) ? 12'h018 : 12'h000;
            wr(1'b1, cv, 1'b1);
            for (int c = 0; c < 4096; c += 273) begin
                wr(1'b0, c, 1'b1);
                chk("R9 vout ref", int'(vout), exp_vout(c, ctrl_m));
            end
            wr(1'b0, 4095, 1'b1);
            chk("R9 vout full", int'(vout), exp_vout(4095, ctrl_m));
        end
        ld_n = 1'b1; ld_low_m = 0; tick(4);

        // R6 / R7: control sweep, ignored bits scrambled
        for (int v = 0; v < 32; v++) begin
            int full = v | ((((v * 37) + 5) & 8'h7F) << 5);
            wr(1'b1, full, 1'b1);
            chk_ctrl("ctrl sweep");
            wr(1'b1, full ^ 12'hFE4, 1'b1);
            chk_ctrl("ctrl ignored bits");
            chk("R2 code kept", int'(code), code_m);
        end

        // R8: power down keeps code
        wr(1'b0, 12'h9AB, 1'b1); ld_pulse();
        wr(1'b1, 12'h00A, 1'b1);
        chk("R8 pwrdn set", int'(pwrdn), 1);
        chk("R8 code during pd", int'(code), 12'h9AB);
        wr(1'b1, 12'h008, 1'b1);
        chk("R8 pwrdn clear", int'(pwrdn), 0);
        chk("R8 code restored", int'(code), 12'h9AB);

        // R13: legal traffic left flags clear
        chk("R13 no flags legal", int'(viol), 0);

        // R10: CS setup violated
        do_reset();
        cs_n = 1'b0; we_n = 1'b0; dat = 12'h111; tick(3); we_n = 1'b1; tick(3); cs_n = 1'b1; tick(4);
        chk("R10 cs setup flag", int'(viol), 7'h01);
        // R10: WE high pulse too short
        do_reset();
        cs_n = 1'b0; tick(3); we_n = 1'b0; tick(3); we_n = 1'b1; tick(1); we_n = 1'b0; tick(3);
        we_n = 1'b1; tick(3); cs_n = 1'b1; tick(4);
        chk("R10 we high flag", int'(viol), 7'h10);
        // R11: data setup
        do_reset();
        cs_n = 1'b0; dat = 12'h0AA; tick(3); we_n = 1'b0; tick(2); dat = 12'h055; tick(1);
        we_n = 1'b1; tick(3); cs_n = 1'b1; tick(4);
        chk("R11 data setup flag", int'(viol), 7'h02);
        // R11: register select setup
        do_reset();
        cs_n = 1'b0; sel = 1'b0; tick(3); we_n = 1'b0; tick(1); sel = 1'b1; tick(2);
        we_n = 1'b1; tick(3); cs_n = 1'b1; sel = 1'b0; tick(4);
        chk("R11 reg setup flag", int'(viol), 7'h04);
        // R11: hold
        do_reset();
        cs_n = 1'b0; dat = 12'h0F0; tick(3); we_n = 1'b0; tick(3); we_n = 1'b1; dat = 12'h00F;
        tick(3); cs_n = 1'b1; tick(4);
        chk("R11 hold flag", int'(viol), 7'h08);
        // R12: load pulse too short
        do_reset();
        ld_n = 1'b0; tick(2); ld_n = 1'b1; tick(5);
        chk("R12 ld low flag", int'(viol), 7'h20);
        // R12: load falls with WE rise
        do_reset();
        cs_n = 1'b0; tick(3); we_n = 1'b0; tick(3); we_n = 1'b1; ld_n = 1'b0; tick(4);
        ld_n = 1'b1; cs_n = 1'b1; tick(4);
        chk("R12 we to ld flag", int'(viol), 7'h40);
        // R13: sticky until reset
        wr(1'b0, 12'h001, 1'b1); ld_pulse();
        chk("R13 flag sticky", int'(viol), 7'h40);
        do_reset();
        chk("R13 cleared by reset", int'(viol), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule